// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps time in a slow low-power clock domain. Every clock of that domain is one tick of 1/2^FRAC_W of a second. The count is held as a single value: a seconds word on top and a sub-second fraction below it. With the default sizes this is a 47-bit count, 32 bits of seconds over 15 bits of fraction, advanced at 32768 ticks per second. The block also holds an alarm value of the same width. When a tick brings the count to the alarm value, a sticky match flag is raised.

Software reaches the block through strobes that are already synchronized into this clock domain. Each strobe comes with a shared data word. There are separate strobes for the seconds word, the fraction word, the two alarm words, the control word and the status (flag-clear) write. The count holds still while the enable bit is clear. It also holds still until the seconds word has been loaded at least once since reset, whatever the enable bit says.

To set the time exactly, load the fraction first and the seconds second. No tick is applied in either load cycle. The match flag is the only event the block produces; there is no periodic event.

Top module: `lp_timekeeper`

## Requirements
- R1: The count is {seconds, fraction}. The fraction is the low FRAC_W bits. It wraps from all ones to zero and carries one into the seconds word. The seconds word wraps from all ones to zero.
- R2: After reset the count does not advance until the seconds word has been loaded, even with the enable bit set.
- R3: The enable bit is bit 3 of the control word, latched by a control write. While it is 0 the count holds its value.
- R4: While enabled and loaded, the count advances by exactly one tick on every clock that carries no seconds or fraction load.
- R5: A seconds or fraction load replaces that word with the data. The other word holds, and no tick is applied in that cycle.
- R6: The match flag is set on the clock where a tick makes the full count equal the full alarm value.
- R7: A load that makes the count equal to the alarm value does not set the match flag.
- R8: The match flag stays set until a status write with data bit 4 set. A status write with bit 4 clear leaves it unchanged. A new match in the same cycle as a clear leaves the flag set.
- R9: Reset gives count 0, enable 0, flag 0, and alarm seconds all ones with alarm fraction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power clock; one tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | SEC_W | Data shared by all write strobes |
| sec_wr | input | 1 | Load seconds word |
| frac_wr | input | 1 | Load fraction word (low FRAC_W bits of data) |
| alm_sec_wr | input | 1 | Load alarm seconds word |
| alm_frac_wr | input | 1 | Load alarm fraction word |
| ctrl_wr | input | 1 | Load control word (bit 3 = enable) |
| stat_wr | input | 1 | Status write; data bit 4 = 1 clears the flag |
| time_sec | output | SEC_W | Current seconds |
| time_frac | output | FRAC_W | Current fraction |
| alm_sec | output | SEC_W | Alarm seconds |
| alm_frac | output | FRAC_W | Alarm fraction |
| run_en | output | 1 | Enable bit |
| match_flag | output | 1 | Sticky alarm match flag |

## Verification
A wrong run condition shows up at the time outputs on the next clock: the count either moves while it should be frozen, or stays put when it should step. A carry that is lost or doubled shows up in the seconds word on the clock after the fraction reaches all ones. A comparator fault shows up on match_flag at the exact clock where the count reaches the alarm, or where it passes the alarm without the flag rising. The bench keeps an arithmetic model of the count and compares both time words and the flag after every clock of a long run. That run includes wraps at both word boundaries.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int EN_BIT   = 3;  // control word: run enable
  localparam int FLAG_BIT = 4;  // status word: write 1 clears match flag
endpackage

// File: rtl/tk_ctrl.sv
module tk_ctrl #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr_i,
  input  logic [SEC_W-1:0] wr_data_i,
  output logic             en_o
);
  import tk_pkg::*;
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)            en_q <= 1'b0;
    else if (ctrl_wr_i) en_q <= wr_data_i[EN_BIT];
  end

  assign en_o = en_q;

  // R3: enable follows bit 3 of a control write, otherwise holds
  a_r3_en_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr_i |=> (en_q == $past(en_q)));
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              sec_wr_i,
  input  logic              frac_wr_i,
  input  logic [SEC_W-1:0]  wr_data_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              tick_o,
  output logic [SEC_W-1:0]  nxt_sec_o,
  output logic [FRAC_W-1:0] nxt_frac_o
);
  localparam logic [FRAC_W-1:0] FRAC_ONE = FRAC_W'(1);
  localparam logic [SEC_W-1:0]  SEC_ONE  = SEC_W'(1);

  logic [SEC_W-1:0]  sec_q;
  logic [FRAC_W-1:0] frac_q;
  logic              loaded_q;
  logic              tick;
  logic              carry;

  assign tick       = en_i && loaded_q && !sec_wr_i && !frac_wr_i;
  assign carry      = &frac_q;
  assign nxt_frac_o = frac_q + FRAC_ONE;
  assign nxt_sec_o  = carry ? (sec_q + SEC_ONE) : sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= '0;
      frac_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (sec_wr_i) begin
        sec_q    <= wr_data_i;
        loaded_q <= 1'b1;
      end
      if (frac_wr_i) frac_q <= wr_data_i[FRAC_W-1:0];
      if (tick) begin
        sec_q  <= nxt_sec_o;
        frac_q <= nxt_frac_o;
      end
    end
  end

  assign sec_o  = sec_q;
  assign frac_o = frac_q;
  assign tick_o = tick;

  // R2: nothing moves before the first seconds load
  a_r2_frozen_unloaded: assert property (@(posedge clk) disable iff (rst)
    (!loaded_q && !sec_wr_i && !frac_wr_i) |=>
      (sec_q == $past(sec_q) && frac_q == $past(frac_q)));

  // R4: fraction steps by one on a running, load-free clock
  a_r4_frac_step: assert property (@(posedge clk) disable iff (rst)
    (en_i && loaded_q && !sec_wr_i && !frac_wr_i) |=>
      (frac_q == $past(frac_q) + FRAC_ONE));

  // R5: a fraction-only load leaves the seconds word alone
  a_r5_frac_load_sec_hold: assert property (@(posedge clk) disable iff (rst)
    (frac_wr_i && !sec_wr_i) |=> (sec_q == $past(sec_q)));
endmodule

// File: rtl/tk_alarm.sv
module tk_alarm #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alm_sec_wr_i,
  input  logic              alm_frac_wr_i,
  input  logic              stat_wr_i,
  input  logic [SEC_W-1:0]  wr_data_i,
  input  logic              tick_i,
  input  logic [SEC_W-1:0]  nxt_sec_i,
  input  logic [FRAC_W-1:0] nxt_frac_i,
  input  logic [SEC_W-1:0]  cnt_sec_i,
  input  logic [FRAC_W-1:0] cnt_frac_i,
  output logic [SEC_W-1:0]  alm_sec_o,
  output logic [FRAC_W-1:0] alm_frac_o,
  output logic              flag_o
);
  import tk_pkg::*;
  localparam int CMP_W = SEC_W + FRAC_W;

  logic [SEC_W-1:0]  alm_sec_q;
  logic [FRAC_W-1:0] alm_frac_q;
  logic              flag_q;
  logic              hit;
  logic              clr;

  assign hit = tick_i && ({nxt_sec_i, nxt_frac_i} == CMP_W'({alm_sec_q, alm_frac_q}));
  assign clr = stat_wr_i && wr_data_i[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_sec_q  <= '1;
      alm_frac_q <= '0;
      flag_q     <= 1'b0;
    end else begin
      if (alm_sec_wr_i)  alm_sec_q  <= wr_data_i;
      if (alm_frac_wr_i) alm_frac_q <= wr_data_i[FRAC_W-1:0];
      flag_q <= hit | (flag_q & ~clr);
    end
  end

  assign alm_sec_o  = alm_sec_q;
  assign alm_frac_o = alm_frac_q;
  assign flag_o     = flag_q;

  // R8: flag holds unless a clearing status write arrives
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);

  // R6: a rising flag means the count now equals the alarm it was compared with
  a_r6_rise_on_match: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> ({cnt_sec_i, cnt_frac_i} == $past({alm_sec_q, alm_frac_q})));
endmodule

// File: rtl/lp_timekeeper.sv
module lp_timekeeper #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEC_W-1:0]  wr_data,
  input  logic              sec_wr,
  input  logic              frac_wr,
  input  logic              alm_sec_wr,
  input  logic              alm_frac_wr,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  output logic [SEC_W-1:0]  time_sec,
  output logic [FRAC_W-1:0] time_frac,
  output logic [SEC_W-1:0]  alm_sec,
  output logic [FRAC_W-1:0] alm_frac,
  output logic              run_en,
  output logic              match_flag
);
  logic              en;
  logic              tick;
  logic [SEC_W-1:0]  nxt_sec;
  logic [FRAC_W-1:0] nxt_frac;

  tk_ctrl #(.SEC_W(SEC_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .wr_data_i(wr_data), .en_o(en)
  );

  tk_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .sec_wr_i(sec_wr), .frac_wr_i(frac_wr),
    .wr_data_i(wr_data), .sec_o(time_sec), .frac_o(time_frac),
    .tick_o(tick), .nxt_sec_o(nxt_sec), .nxt_frac_o(nxt_frac)
  );

  tk_alarm #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_alm (
    .clk(clk), .rst(rst), .alm_sec_wr_i(alm_sec_wr), .alm_frac_wr_i(alm_frac_wr),
    .stat_wr_i(stat_wr), .wr_data_i(wr_data), .tick_i(tick),
    .nxt_sec_i(nxt_sec), .nxt_frac_i(nxt_frac),
    .cnt_sec_i(time_sec), .cnt_frac_i(time_frac),
    .alm_sec_o(alm_sec), .alm_frac_o(alm_frac), .flag_o(match_flag)
  );

  assign run_en = en;

  initial begin
    a_r1_widths: assert (FRAC_W <= SEC_W && SEC_W > 4);
  end
endmodule

// File: tb/lp_timekeeper_test.sv
`timescale 1ns/100ps
module lp_timekeeper_test;
  localparam int SW = 8;
  localparam int FW = 4;
  localparam int TOT = 1 << (SW + FW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] wr_data = '0;
  logic sec_wr = 0, frac_wr = 0, alm_sec_wr = 0, alm_frac_wr = 0, ctrl_wr = 0, stat_wr = 0;
  logic [SW-1:0] time_sec, alm_sec;
  logic [FW-1:0] time_frac, alm_frac;
  logic run_en, match_flag;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_alm = 0;
  bit m_en = 0, m_loaded = 0, m_flag = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_timekeeper #(.SEC_W(SW), .FRAC_W(FW)) uut (
    .clk(clk), .rst(rst), .wr_data(wr_data), .sec_wr(sec_wr), .frac_wr(frac_wr),
    .alm_sec_wr(alm_sec_wr), .alm_frac_wr(alm_frac_wr), .ctrl_wr(ctrl_wr),
    .stat_wr(stat_wr), .time_sec(time_sec), .time_frac(time_frac),
    .alm_sec(alm_sec), .alm_frac(alm_frac), .run_en(run_en), .match_flag(match_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_time(input string req);
    chk(req, {time_sec, time_frac}, m_cnt);
    chk(req, match_flag, m_flag);
  endtask

  // kind: 0 none, 1 sec, 2 frac, 3 alm sec, 4 alm frac, 5 ctrl, 6 stat
  task automatic cyc(input int kind, input int data);
    bit load, hit, clr;
    int nxt;
    wr_data = SW'(data);
    sec_wr = (kind == 1); frac_wr = (kind == 2); alm_sec_wr = (kind == 3);
    alm_frac_wr = (kind == 4); ctrl_wr = (kind == 5); stat_wr = (kind == 6);
    @(negedge clk);
    load = (kind == 1) || (kind == 2);
    hit = 0;
    if (m_en && m_loaded && !load) begin
      nxt = (m_cnt + 1) % TOT;
      hit = (nxt == m_alm);
      m_cnt = nxt;
    end
    clr = (kind == 6) && data[4];
    m_flag = hit | (m_flag & !clr);
    if (kind == 1) begin m_cnt = (data % (1 << SW)) * (1 << FW) + (m_cnt % (1 << FW)); m_loaded = 1; end
    if (kind == 2) m_cnt = (m_cnt / (1 << FW)) * (1 << FW) + (data % (1 << FW));
    if (kind == 3) m_alm = (data % (1 << SW)) * (1 << FW) + (m_alm % (1 << FW));
    if (kind == 4) m_alm = (m_alm / (1 << FW)) * (1 << FW) + (data % (1 << FW));
    if (kind == 5) m_en = data[3];
    sec_wr = 0; frac_wr = 0; alm_sec_wr = 0; alm_frac_wr = 0; ctrl_wr = 0; stat_wr = 0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    m_alm = ((1 << SW) - 1) * (1 << FW);
    // R9 reset state
    chk("R9 count", {time_sec, time_frac}, 0);
    chk("R9 enable", run_en, 0);
    chk("R9 flag", match_flag, 0);
    chk("R9 alarm sec", alm_sec, (1 << SW) - 1);
    chk("R9 alarm frac", alm_frac, 0);

    // R3 enable bit position; R2 frozen before first seconds load
    cyc(5, 8);
    chk("R3 enable set", run_en, 1);
    for (int i = 0; i < 20; i++) cyc(0, 0);
    chk_time("R2 frozen unloaded");

    // R5 exact load: fraction then seconds, no tick in load cycles
    cyc(2, 5);
    chk_time("R5 frac load");
    cyc(1, 10);
    chk("R5 exact set", {time_sec, time_frac}, 10 * 16 + 5);

    // R4 / R1 step and carry sweep
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0);
      chk_time("R4 step");
    end

    // R3 disable holds count; other control bits ignored
    cyc(5, 8'hF7);
    chk("R3 enable cleared", run_en, 0);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0);
      chk_time("R3 hold");
    end

    // R6 alarm match by ticking, then R8 sticky
    cyc(3, 14);
    cyc(4, 2);
    chk("R6 alarm value", {alm_sec, alm_frac}, 14 * 16 + 2);
    cyc(5, 8);
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0);
      chk_time("R6 match / R8 sticky");
    end
    chk("R6 flag reached", match_flag, 1);

    // R8 status write with bit 4 clear: no effect; bit 4 set: clears
    cyc(6, 8'hEF);
    chk("R8 no clear", match_flag, 1);
    cyc(6, 8'h10);
    chk("R8 cleared", match_flag, 0);

    // R7 loading count to alarm does not set flag
    cyc(5, 0);
    cyc(2, 2);
    cyc(1, 14);
    chk("R7 count at alarm", {time_sec, time_frac}, 14 * 16 + 2);
    chk("R7 no flag on load", match_flag, 0);

    // R8 match and clear in the same cycle: set wins
    cyc(2, 1);
    cyc(5, 8);
    chk_time("R8 pre");
    cyc(6, 8'h10);
    chk("R8 set beats clear", match_flag, 1);
    cyc(6, 8'h10);
    chk("R8 later clear", match_flag, 0);

    // R1 wrap of both words
    cyc(2, 15);
    cyc(1, 255);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0);
      chk_time("R1 wrap");
    end
    chk("R1 wrapped to zero sec", time_sec, 0);

    // R1 long sweep across many seconds
    for (int i = 0; i < 3000; i++) begin
      cyc(0, 0);
      chk_time("R1 sweep");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule